// File: doc/BRIEF.md
# Hierarchical Stereo Matching Cost Generator

This block turns one pair of rectified scan lines into a stack of matching costs at four scale levels. Left and right pixels arrive one pair per cycle while the block is ready to load. When a full line is held, the block sweeps through every disparity, one per cycle. In each step it shifts the right line by one more position and forms a truncated, weighted absolute difference at every pixel. That gives the finest cost vector for that disparity.

Coarser vectors are made from the finest ones. Neighbouring costs along the line are first added in pairs. The sums are then accumulated over a group of consecutive lines, so a node at level k covers a square window of 2^k by 2^k pixels. Each coarse level reports its vector only while the last line of its group is being swept. Its accumulator then starts the next group from zero. A downstream message-passing engine takes the four vectors per disparity as its data costs.

Top module: `stereo_cost_pyramid`

## Requirements
- R1: After reset, cost_valid is 0, lvl_valid is 0 and load_ready is 1.
- R2: While load_ready is 1, each cycle with pix_valid high stores one left/right pair at the next line position, 0 to LINE_W-1 in arrival order. The cycle after the LINE_W-th pair is taken, load_ready is 0.
- R3: Pixel pairs offered while load_ready is 0 are ignored and do not change any later cost.
- R4: The first result appears on the second clock edge after the last pixel of a line is taken. cost_valid then stays high for NDISP consecutive cycles, and cost_disp counts 0, 1, ... NDISP-1. load_ready returns to 1 in the same cycle as disparity NDISP-1 and cost_valid falls on the next cycle.
- R5: Level-0 field x (bits [x*10 +: 10] of cost_l0) for disparity d is min(4*|R[x+d] - L[x]|, 60).
- R6: When x+d is at or beyond LINE_W, the level-0 cost is 60.
- R7: Lines are numbered from 0 after reset. A level-k group is 2^k consecutive lines, with level-k groups starting at line numbers that are multiples of 2^k. Level-k field n (10 bits at [n*10 +: 10]) is the sum of the level-0 costs of pixels n*2^k to n*2^k+2^k-1 over all lines of the group.
- R8: lvl_valid bit k-1 (level k, k = 1..3) is high exactly during the NDISP results of the last line of a level-k group.
- R9: After a group completes, the level-k accumulation starts again from zero for the next group.
- R10: Any coarse sum above 1023 is reported as 1023.
- R11: If level-3 is flagged valid, levels 2 and 1 are flagged valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | A pixel pair is offered |
| pix_left | input | PIX_W | Left-image pixel |
| pix_right | input | PIX_W | Right-image pixel |
| load_ready | output | 1 | Block accepts pixel pairs |
| cost_valid | output | 1 | Cost vectors valid this cycle |
| cost_disp | output | clog2(NDISP) | Disparity of the current vectors |
| lvl_valid | output | 3 | Bit k-1 flags level k as valid |
| cost_l0 | output | LINE_W*CW | Level-0 costs, one field per pixel |
| cost_l1 | output | LINE_W/2*CW | Level-1 costs |
| cost_l2 | output | LINE_W/4*CW | Level-2 costs |
| cost_l3 | output | LINE_W/8*CW | Level-3 costs |

## Verification
The assertions check the properties that hold in every cycle: the disparity count advancing by one through a sweep, the truncation bound on level-0 fields, the nesting of level flags and their tie to cost_valid, and the return of load_ready on the final disparity. The actual cost values, the right-edge fill, the group boundaries, the clearing of the accumulators, the saturation of level 3 and the ignoring of pixels offered during a sweep can only be shown by the bench's scenarios. In those scenarios a behavioural model tracks line numbers and group sums and is compared with the outputs on every clock.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic {PH_LOAD = 1'b0, PH_SWEEP = 1'b1} phase_e;

  // saturating add of two non-negative values against a ceiling
  function automatic logic [31:0] sat_add(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] lim);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s > {1'b0, lim}) return lim;
    return s[31:0];
  endfunction

endpackage

// File: rtl/dc_line_regs.sv
module dc_line_regs #(
  parameter int LINE_W = 16,
  parameter int PIX_W  = 8,
  localparam int WW    = $clog2(LINE_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_en,
  input  logic [WW-1:0]           wr_idx,
  input  logic [PIX_W-1:0]        pix_left,
  input  logic [PIX_W-1:0]        pix_right,
  input  logic                    shift_en,
  output logic [LINE_W*PIX_W-1:0] lvec,
  output logic [LINE_W*PIX_W-1:0] rvec,
  output logic [LINE_W-1:0]       rvld
);

  logic [PIX_W-1:0] l_q [LINE_W];
  logic [PIX_W-1:0] l_d [LINE_W];
  logic [PIX_W-1:0] r_q [LINE_W];
  logic [PIX_W-1:0] r_d [LINE_W];
  logic [LINE_W-1:0] v_q, v_d;

  always_comb begin
    l_d = l_q;
    r_d = r_q;
    v_d = v_q;
    if (load_en) begin
      l_d[wr_idx] = pix_left;
      r_d[wr_idx] = pix_right;
      v_d[wr_idx] = 1'b1;
    end else if (shift_en) begin
      // right line slides one place toward position 0 per disparity step
      for (int x = 0; x < LINE_W - 1; x++) begin
        r_d[x] = r_q[x+1];
        v_d[x] = v_q[x+1];
      end
      r_d[LINE_W-1] = '0;
      v_d[LINE_W-1] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en || shift_en) begin
      l_q <= l_d;
      r_q <= r_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else if (load_en || shift_en) v_q <= v_d;
  end

  for (genvar x = 0; x < LINE_W; x++) begin : g_out
    assign lvec[x*PIX_W +: PIX_W] = l_q[x];
    assign rvec[x*PIX_W +: PIX_W] = r_q[x];
  end
  assign rvld = v_q;

endmodule

// File: rtl/dc_abs_cost.sv
module dc_abs_cost #(
  parameter int PIX_W = 8,
  parameter int CW    = 10,
  parameter int CD    = 4,
  parameter int KD    = 60
) (
  input  logic [PIX_W-1:0] lpix,
  input  logic [PIX_W-1:0] rpix,
  input  logic             rok,
  output logic [CW-1:0]    cost
);

  logic [PIX_W-1:0] diff;
  logic [31:0]      prod;

  always_comb begin
    diff = (lpix > rpix) ? (lpix - rpix) : (rpix - lpix);
    prod = 32'(CD) * 32'(diff);
    if (!rok || prod > 32'(KD)) cost = CW'(KD);
    else                        cost = CW'(prod);
  end

endmodule

// File: rtl/dc_pair_sum.sv
module dc_pair_sum #(
  parameter int N_IN  = 16,
  parameter int CW    = 10,
  localparam int NOUT = N_IN / 2,
  localparam logic [31:0] LIM = 32'((1 << CW) - 1)
) (
  input  logic [N_IN*CW-1:0] sum_in,
  output logic [NOUT*CW-1:0] sum_out
);

  for (genvar n = 0; n < NOUT; n++) begin : g_pair
    assign sum_out[n*CW +: CW] =
      CW'(stc_pkg::sat_add(32'(sum_in[(2*n)*CW +: CW]), 32'(sum_in[(2*n+1)*CW +: CW]), LIM));
  end

endmodule

// File: rtl/dc_level_acc.sv
module dc_level_acc #(
  parameter int NODES = 8,
  parameter int NDISP = 32,
  parameter int CW    = 10,
  localparam int DW   = $clog2(NDISP),
  localparam logic [31:0] LIM = 32'((1 << CW) - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DW-1:0]     disp,
  input  logic              grp_last,
  input  logic [NODES*CW-1:0] hsum,
  output logic [NODES*CW-1:0] sum_o,
  output logic              sum_vld
);

  logic [CW-1:0] acc_q [NDISP][NODES];
  logic [CW-1:0] tot   [NODES];
  logic [CW-1:0] out_q [NODES];

  always_comb begin
    for (int n = 0; n < NODES; n++)
      tot[n] = CW'(stc_pkg::sat_add(32'(acc_q[disp][n]), 32'(hsum[n*CW +: CW]), LIM));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NDISP; d++)
        for (int n = 0; n < NODES; n++)
          acc_q[d][n] <= '0;
      sum_vld <= 1'b0;
    end else begin
      sum_vld <= en && grp_last;
      if (en) begin
        for (int n = 0; n < NODES; n++)
          acc_q[disp][n] <= grp_last ? '0 : tot[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en && grp_last) out_q <= tot;
  end

  for (genvar n = 0; n < NODES; n++) begin : g_o
    assign sum_o[n*CW +: CW] = out_q[n];
  end

endmodule

// File: rtl/stereo_cost_pyramid.sv
module stereo_cost_pyramid #(
  parameter int LINE_W = 16,
  parameter int PIX_W  = 8,
  parameter int NDISP  = 32,
  parameter int CW     = 10,
  parameter int CD     = 4,
  parameter int KD     = 60,
  localparam int NLEV  = 4,
  localparam int DW    = $clog2(NDISP),
  localparam int WW    = $clog2(LINE_W)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pix_valid,
  input  logic [PIX_W-1:0]            pix_left,
  input  logic [PIX_W-1:0]            pix_right,
  output logic                        load_ready,
  output logic                        cost_valid,
  output logic [DW-1:0]               cost_disp,
  output logic [NLEV-2:0]             lvl_valid,
  output logic [LINE_W*CW-1:0]        cost_l0,
  output logic [(LINE_W/2)*CW-1:0]    cost_l1,
  output logic [(LINE_W/4)*CW-1:0]    cost_l2,
  output logic [(LINE_W/8)*CW-1:0]    cost_l3
);
  import stc_pkg::*;

  localparam logic [WW-1:0] WR_LAST = WW'(LINE_W - 1);
  localparam logic [DW-1:0] D_LAST  = DW'(NDISP - 1);

  // reset: asserted at once, released through two flops
  logic rs1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1   <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rs1   <= 1'b1;
      rst_i <= rs1;
    end
  end

  phase_e           ph_q, ph_d;
  logic [WW-1:0]    wr_q, wr_d;
  logic [DW-1:0]    d_q, d_d;
  logic [NLEV-2:0]  grp_q, grp_d;
  logic             take, sweep;

  assign take  = (ph_q == PH_LOAD) && pix_valid;
  assign sweep = (ph_q == PH_SWEEP);

  always_comb begin
    ph_d  = ph_q;
    wr_d  = wr_q;
    d_d   = d_q;
    grp_d = grp_q;
    if (take) begin
      wr_d = wr_q + 1'b1;
      if (wr_q == WR_LAST) begin
        wr_d = '0;
        d_d  = '0;
        ph_d = PH_SWEEP;
      end
    end
    if (sweep) begin
      d_d = d_q + 1'b1;
      if (d_q == D_LAST) begin
        ph_d  = PH_LOAD;
        grp_d = grp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ph_q  <= PH_LOAD;
      wr_q  <= '0;
      d_q   <= '0;
      grp_q <= '0;
    end else begin
      ph_q  <= ph_d;
      wr_q  <= wr_d;
      d_q   <= d_d;
      grp_q <= grp_d;
    end
  end

  assign load_ready = (ph_q == PH_LOAD);

  // line storage
  logic [LINE_W*PIX_W-1:0] lvec, rvec;
  logic [LINE_W-1:0]       rvld;

  dc_line_regs #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_lines (
    .clk      (clk),
    .rst_n    (rst_i),
    .load_en  (take),
    .wr_idx   (wr_q),
    .pix_left (pix_left),
    .pix_right(pix_right),
    .shift_en (sweep),
    .lvec     (lvec),
    .rvec     (rvec),
    .rvld     (rvld)
  );

  // per-pixel level-0 costs and the horizontal reduction tree
  logic [LINE_W*CW-1:0] hs [NLEV];
  logic [LINE_W*CW-1:0] lo [1:NLEV-1];

  for (genvar x = 0; x < LINE_W; x++) begin : g_px
    dc_abs_cost #(.PIX_W(PIX_W), .CW(CW), .CD(CD), .KD(KD)) u_ad (
      .lpix(lvec[x*PIX_W +: PIX_W]),
      .rpix(rvec[x*PIX_W +: PIX_W]),
      .rok (rvld[x]),
      .cost(hs[0][x*CW +: CW])
    );
  end

  for (genvar k = 1; k < NLEV; k++) begin : g_lvl
    localparam int NIN  = LINE_W >> (k - 1);
    localparam int NOUT = LINE_W >> k;
    logic grp_last;
    assign grp_last = &grp_q[k-1:0];

    dc_pair_sum #(.N_IN(NIN), .CW(CW)) u_pair (
      .sum_in (hs[k-1][NIN*CW-1:0]),
      .sum_out(hs[k][NOUT*CW-1:0])
    );
    assign hs[k][LINE_W*CW-1:NOUT*CW] = '0;

    dc_level_acc #(.NODES(NOUT), .NDISP(NDISP), .CW(CW)) u_acc (
      .clk     (clk),
      .rst_n   (rst_i),
      .en      (sweep),
      .disp    (d_q),
      .grp_last(grp_last),
      .hsum    (hs[k][NOUT*CW-1:0]),
      .sum_o   (lo[k][NOUT*CW-1:0]),
      .sum_vld (lvl_valid[k-1])
    );
    assign lo[k][LINE_W*CW-1:NOUT*CW] = '0;
  end

  // level-0 output register
  logic [LINE_W*CW-1:0] l0_q;
  logic [DW-1:0]        disp_q;
  logic                 vld_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) vld_q <= 1'b0;
    else        vld_q <= sweep;
  end

  always_ff @(posedge clk) begin
    if (sweep) begin
      l0_q   <= hs[0];
      disp_q <= d_q;
    end
  end

  assign cost_valid = vld_q;
  assign cost_disp  = disp_q;
  assign cost_l0    = l0_q;
  assign cost_l1    = lo[1][(LINE_W/2)*CW-1:0];
  assign cost_l2    = lo[2][(LINE_W/4)*CW-1:0];
  assign cost_l3    = lo[3][(LINE_W/8)*CW-1:0];

endmodule

// File: rtl/stereo_cost_pyramid_chk.sv
module stereo_cost_pyramid_chk #(
  parameter int LINE_W = 16,
  parameter int NDISP  = 32,
  parameter int CW     = 10,
  parameter int KD     = 60,
  localparam int DW    = $clog2(NDISP)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 load_ready,
  input logic                 cost_valid,
  input logic [DW-1:0]        cost_disp,
  input logic [2:0]           lvl_valid,
  input logic [LINE_W*CW-1:0] cost_l0
);

  // R4
  disp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cost_valid && cost_disp != DW'(NDISP - 1)) |=>
      (cost_valid && cost_disp == $past(cost_disp) + 1'b1));

  // R4
  sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cost_valid) |-> (cost_disp == '0));

  // R4
  ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_ready) |-> (cost_valid && cost_disp == DW'(NDISP - 1)));

  // R8
  lvl_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_valid != '0) |-> cost_valid);

  // R11
  lvl_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_valid[2] |-> (lvl_valid[1] && lvl_valid[0]));

  for (genvar x = 0; x < LINE_W; x++) begin : g_b
    // R5
    l0_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cost_valid |-> (cost_l0[x*CW +: CW] <= CW'(KD)));
  end

endmodule

bind stereo_cost_pyramid stereo_cost_pyramid_chk #(
  .LINE_W(LINE_W), .NDISP(NDISP), .CW(CW), .KD(KD)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_ready(load_ready),
  .cost_valid(cost_valid),
  .cost_disp (cost_disp),
  .lvl_valid (lvl_valid),
  .cost_l0   (cost_l0)
);

// File: tb/stereo_cost_pyramid_tb.sv
module stereo_cost_pyramid_tb_top;

  localparam int LW = 16;
  localparam int ND = 32;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0;
  logic [7:0] pix_left = '0, pix_right = '0;
  logic load_ready, cost_valid;
  logic [4:0] cost_disp;
  logic [2:0] lvl_valid;
  logic [LW*CW-1:0] cost_l0;
  logic [(LW/2)*CW-1:0] cost_l1;
  logic [(LW/4)*CW-1:0] cost_l2;
  logic [(LW/8)*CW-1:0] cost_l3;

  always #2 clk = ~clk;

  stereo_cost_pyramid dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_left(pix_left),
    .pix_right(pix_right), .load_ready(load_ready), .cost_valid(cost_valid),
    .cost_disp(cost_disp), .lvl_valid(lvl_valid), .cost_l0(cost_l0),
    .cost_l1(cost_l1), .cost_l2(cost_l2), .cost_l3(cost_l3)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, line_no = 0;
  bit done = 0;
  int lp [LW];
  int rp [LW];
  int e0 [ND][LW];
  int acc [1:3][ND][LW];
  int ek [1:3][ND][LW];
  bit ev [1:3];

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d (line %0d)", req, got, exp, line_no);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // behavioural model: costs for the line held in lp/rp (R5, R6, R7, R9, R10)
  task automatic model_line();
    for (int d = 0; d < ND; d++)
      for (int x = 0; x < LW; x++) begin
        int c;
        if (x + d >= LW) c = 60;
        else begin
          c = rp[x+d] - lp[x];
          if (c < 0) c = -c;
          c = c * 4;
          if (c > 60) c = 60;
        end
        e0[d][x] = c;
      end
    for (int k = 1; k <= 3; k++) begin
      int span = 1 << k;
      ev[k] = ((line_no % span) == span - 1);
      for (int d = 0; d < ND; d++)
        for (int n = 0; n < (LW >> k); n++) begin
          for (int j = 0; j < span; j++) acc[k][d][n] += e0[d][n*span + j];
          ek[k][d][n] = (acc[k][d][n] > 1023) ? 1023 : acc[k][d][n];
          if (ev[k]) acc[k][d][n] = 0;
        end
    end
  endtask

  task automatic run_line(input bit junk);
    model_line();
    for (int x = 0; x < LW; x++) begin
      @(negedge clk);
      if (x == 0) chk("R2 ready before load", int'(load_ready), 1);
      pix_valid = 1'b1;
      pix_left  = 8'(lp[x]);
      pix_right = 8'(rp[x]);
    end
    for (int k = 1; k <= 34; k++) begin
      @(negedge clk);
      if (junk && k <= 32) begin
        pix_valid = 1'b1;
        pix_left  = 8'($urandom);
        pix_right = 8'($urandom);
      end else pix_valid = 1'b0;
      chk("R4 cost_valid timing", int'(cost_valid), (k >= 2 && k <= 33) ? 1 : 0);
      chk("R2 load_ready", int'(load_ready), (k >= 33) ? 1 : 0);
      if (k >= 2 && k <= 33) begin
        int d = k - 2;
        chk("R4 disparity", int'(cost_disp), d);
        for (int x = 0; x < LW; x++)
          chk((x + d >= LW) ? "R6 edge cost" : "R5 level0 cost", int'(cost_l0[x*CW +: CW]), e0[d][x]);
        for (int k2 = 1; k2 <= 3; k2++)
          chk("R8 level flag", int'(lvl_valid[k2-1]), int'(ev[k2]));
        if (ev[1]) for (int n = 0; n < LW/2; n++) chk("R7 level1", int'(cost_l1[n*CW +: CW]), ek[1][d][n]);
        if (ev[2]) for (int n = 0; n < LW/4; n++) chk("R9 level2", int'(cost_l2[n*CW +: CW]), ek[2][d][n]);
        if (ev[3]) for (int n = 0; n < LW/8; n++) chk("R10 level3", int'(cost_l3[n*CW +: CW]), ek[3][d][n]);
      end else
        chk("R8 flags idle", int'(lvl_valid), 0);
    end
    line_no++;
  endtask

  initial begin
    for (int k = 1; k <= 3; k++)
      for (int d = 0; d < ND; d++)
        for (int n = 0; n < LW; n++) acc[k][d][n] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cost_valid", int'(cost_valid), 0);
    chk("R1 lvl_valid", int'(lvl_valid), 0);
    chk("R1 load_ready", int'(load_ready), 1);
    // group 0: random lines, junk on odd lines (R3)
    for (int i = 0; i < 8; i++) begin
      for (int x = 0; x < LW; x++) begin
        lp[x] = int'($urandom % 256);
        rp[x] = int'($urandom % 256);
      end
      run_line(i[0]);
    end
    // group 1: full-contrast lines push level 3 into saturation (R10)
    for (int i = 0; i < 8; i++) begin
      for (int x = 0; x < LW; x++) begin
        lp[x] = 0;
        rp[x] = 255;
      end
      run_line(1'b1);
    end
    // group 2: shifted ramp and small differences (R5 weighting, R9 fresh start)
    for (int i = 0; i < 8; i++) begin
      for (int x = 0; x < LW; x++) begin
        lp[x] = (i < 4) ? 10 * x : 100;
        rp[x] = (i < 4) ? ((x >= 5) ? 10 * (x - 5) : 7) : 102 + (x % 3);
      end
      run_line(i[1]);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule